// File: doc/BRIEF.md
# CPU Interrupt Enable Controller

This block keeps the interrupt-enable state of an 8-bit CPU core and decides, at each instruction boundary, whether a pending interrupt is taken. The instruction decoder drives it with one-cycle strobes for enable, disable, return-from-NMI, load-A-from-special-register and instruction end. A level maskable request and an active-low non-maskable request line come from the peripherals. The block answers with one-cycle accept pulses for each source, the two enable flags, and a parity-flag value with its write strobe.

Two flags are kept. The live flag gates maskable requests. The shadow flag remembers the live flag across a non-maskable service, so that a return from that service restores it. After an enable, maskable acceptance is held off for a configurable number of boundaries, one by default, so that the instruction after the enable (typically a return) completes first.

Top module: `irq_enable_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, ie_live_o, ie_shadow_o, take_int_o, take_nmi_o, parity_we_o and parity_o are all 0.
- R2: An ei_i strobe sets both flags at the next clock edge. A di_i strobe clears both flags at the next clock edge.
- R3: take_int_o is high only in a cycle where boundary_i is high, int_req_i is high, the live flag is 1, no NMI is pending and the enable hold-off is not active.
- R4: With EI_SHADOW = N, a boundary that coincides with ei_i, and each boundary after ei_i until N boundaries have been counted (a coincident one included), does not accept a maskable request.
- R5: Taking a maskable interrupt clears both flags at the next clock edge.
- R6: A falling edge on nmi_n_i, seen after SYNC_STAGES synchronizer flops, is latched as pending. A pending NMI raises take_nmi_o at the next boundary whatever the flags hold, and the pending state is cleared when it is taken.
- R7: When an NMI is pending at a boundary, take_int_o stays low and only take_nmi_o is raised.
- R8: Taking an NMI clears the live flag and leaves the shadow flag unchanged, unless ei_i or di_i coincides with the boundary, in which case the shadow flag follows that strobe.
- R9: A retn_i strobe copies the shadow flag into the live flag at the next clock edge.
- R10: One cycle after ld_spec_i, parity_we_o is 1 for one cycle and parity_o carries the shadow flag value from the cycle of the strobe. parity_o holds that value until the next ld_spec_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| retn_i | input | 1 | Return-from-NMI instruction strobe |
| ld_spec_i | input | 1 | Load A from vector or refresh register strobe |
| boundary_i | input | 1 | Instruction-boundary strobe |
| int_req_i | input | 1 | Maskable request, level |
| nmi_n_i | input | 1 | Non-maskable request, active low, edge sensitive |
| take_int_o | output | 1 | Maskable interrupt accepted this cycle |
| take_nmi_o | output | 1 | Non-maskable interrupt accepted this cycle |
| ie_live_o | output | 1 | Live enable flag |
| ie_shadow_o | output | 1 | Shadow enable flag |
| parity_o | output | 1 | Parity-flag value for the load instruction |
| parity_we_o | output | 1 | Parity-flag write strobe |

## Verification
The bench builds the block with SYNC_STAGES = 2 and EI_SHADOW = 1. These are the values a core uses, and they make the NMI latency and the single-instruction enable hold-off short enough that random strobes often land an enable, a return or an NMI edge on the same boundary as a pending request. The two-stage synchronizer also lets the bench place NMI edges so that they arrive while the live flag is set and while it is clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_INT  = 2'd1,
    ACC_NMI  = 2'd2
  } accept_e;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_n_i,
  input  logic clear_i,
  output logic pend_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   pend_q;
  logic                   fall;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b1;
        else         sync_q[0] <= nmi_n_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign fall = last_q & ~sync_q[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      last_q <= sync_q[LAST];
      // a fresh edge wins over the clear of an older one
      pend_q <= fall | (pend_q & ~clear_i);
    end
  end

  assign pend_o = pend_q;

  p_nmi_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> pend_q);
  p_nmi_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !fall) |=> !pend_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int EI_SHADOW = 1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    boundary_i,
  input  logic    ei_i,
  input  logic    live_i,
  input  logic    int_req_i,
  input  logic    nmi_pend_i,
  output accept_e accept_o
);
  localparam int HOLD_W = $clog2(EI_SHADOW + 1);
  localparam logic [HOLD_W-1:0] HOLD_FULL = HOLD_W'(EI_SHADOW);
  localparam logic [HOLD_W-1:0] HOLD_LESS = HOLD_W'(EI_SHADOW - 1);

  logic [HOLD_W-1:0] hold_q;
  logic              hold_act;

  assign hold_act = ei_i | (hold_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hold_q <= '0;
    else if (ei_i)                      hold_q <= boundary_i ? HOLD_LESS : HOLD_FULL;
    else if (boundary_i && hold_q != '0) hold_q <= hold_q - 1'b1;
  end

  always_comb begin
    accept_o = ACC_NONE;
    if (boundary_i) begin
      if (nmi_pend_i)                             accept_o = ACC_NMI;
      else if (live_i && int_req_i && !hold_act)  accept_o = ACC_INT;
    end
  end

  p_ei_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ei_i |-> accept_o != ACC_INT);
  p_nmi_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && nmi_pend_i) |-> accept_o == ACC_NMI);
  p_int_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o == ACC_INT) |-> (live_i && int_req_i && boundary_i));
endmodule

// File: rtl/irq_flags.sv
module irq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic retn_i,
  input  logic ld_spec_i,
  input  logic take_int_i,
  input  logic take_nmi_i,
  output logic live_o,
  output logic shadow_o,
  output logic parity_o,
  output logic parity_we_o
);
  logic live_q, shadow_q, live_d, shadow_d;
  logic par_q, par_we_q;

  always_comb begin
    shadow_d = shadow_q;
    if (ei_i)            shadow_d = 1'b1;
    else if (di_i)       shadow_d = 1'b0;
    else if (take_int_i) shadow_d = 1'b0;

    live_d = live_q;
    if (take_int_i || take_nmi_i) live_d = 1'b0;
    else if (ei_i)                live_d = 1'b1;
    else if (di_i)                live_d = 1'b0;
    else if (retn_i)              live_d = shadow_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q   <= 1'b0;
      shadow_q <= 1'b0;
      par_q    <= 1'b0;
      par_we_q <= 1'b0;
    end else begin
      live_q   <= live_d;
      shadow_q <= shadow_d;
      par_we_q <= ld_spec_i;
      if (ld_spec_i) par_q <= shadow_q;
    end
  end

  assign live_o      = live_q;
  assign shadow_o    = shadow_q;
  assign parity_o    = par_q;
  assign parity_we_o = par_we_q;

  p_int_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_int_i |=> (!live_q && !shadow_q));
  p_nmi_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_nmi_i && !ei_i && !di_i) |=> (!live_q && shadow_q == $past(shadow_q)));
  p_retn_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retn_i && !ei_i && !di_i && !take_int_i && !take_nmi_i) |=> live_q == $past(shadow_q));
  p_ei_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !take_nmi_i) |=> (live_q && shadow_q));
  p_parity_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_spec_i |=> (par_we_q && par_q == $past(shadow_q)));
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EI_SHADOW   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic retn_i,
  input  logic ld_spec_i,
  input  logic boundary_i,
  input  logic int_req_i,
  input  logic nmi_n_i,
  output logic take_int_o,
  output logic take_nmi_o,
  output logic ie_live_o,
  output logic ie_shadow_o,
  output logic parity_o,
  output logic parity_we_o
);
  accept_e acc;
  logic    nmi_pend, live, shadow;

  irq_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nmi_n_i (nmi_n_i),
    .clear_i (take_nmi_o),
    .pend_o  (nmi_pend)
  );

  irq_arbiter #(.EI_SHADOW(EI_SHADOW)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary_i),
    .ei_i       (ei_i),
    .live_i     (live),
    .int_req_i  (int_req_i),
    .nmi_pend_i (nmi_pend),
    .accept_o   (acc)
  );

  assign take_int_o = (acc == ACC_INT);
  assign take_nmi_o = (acc == ACC_NMI);

  irq_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ei_i        (ei_i),
    .di_i        (di_i),
    .retn_i      (retn_i),
    .ld_spec_i   (ld_spec_i),
    .take_int_i  (take_int_o),
    .take_nmi_i  (take_nmi_o),
    .live_o      (live),
    .shadow_o    (shadow),
    .parity_o    (parity_o),
    .parity_we_o (parity_we_o)
  );

  assign ie_live_o   = live;
  assign ie_shadow_o = shadow;

  p_take_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_int_o && take_nmi_o));
  p_take_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_int_o || take_nmi_o) |-> boundary_i);
endmodule

// File: tb/sim_irq_enable_ctrl.sv
`timescale 1ns/1ps
module sim_irq_enable_ctrl;
  localparam int SYNC = 2;
  localparam int SH   = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ei = 0, di = 0, retn = 0, ld = 0, bnd = 0, req = 0, nmi_n = 1;
  logic take_int, take_nmi, live, shadow, par, par_we;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench reference state
  logic m_live, m_shadow, m_pend, m_prev, m_par, m_pwe;
  logic [SYNC-1:0] m_sync;
  int m_hold;

  always #10 clk = ~clk;

  irq_enable_ctrl #(.SYNC_STAGES(SYNC), .EI_SHADOW(SH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ei_i(ei), .di_i(di), .retn_i(retn),
    .ld_spec_i(ld), .boundary_i(bnd), .int_req_i(req), .nmi_n_i(nmi_n),
    .take_int_o(take_int), .take_nmi_o(take_nmi), .ie_live_o(live),
    .ie_shadow_o(shadow), .parity_o(par), .parity_we_o(par_we)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  function automatic logic exp_nmi();
    return bnd & m_pend;
  endfunction

  function automatic logic exp_int();
    return bnd & ~m_pend & m_live & req & ~(ei | (m_hold != 0));
  endfunction

  task automatic model_reset();
    m_live = 0; m_shadow = 0; m_pend = 0; m_prev = 1;
    m_par = 0; m_pwe = 0; m_sync = '1; m_hold = 0;
  endtask

  // called mid-cycle after inputs settle: check, then advance the reference
  task automatic step();
    logic ti, tn, fall, nl, ns;
    #5;
    ti = exp_int(); tn = exp_nmi();
    chk(take_int, ti, "R3 R4 R7 take_int");
    chk(take_nmi, tn, "R6 R7 take_nmi");
    chk(live, m_live, "R2 R5 R8 R9 ie_live");
    chk(shadow, m_shadow, "R2 R5 R8 ie_shadow");
    chk(par_we, m_pwe, "R10 parity_we");
    chk(par, m_par, "R10 parity");
    fall = m_prev & ~m_sync[SYNC-1];
    m_prev = m_sync[SYNC-1];
    m_sync = {m_sync[SYNC-2:0], nmi_n};
    m_pend = fall | (m_pend & ~tn);
    ns = ei ? 1'b1 : di ? 1'b0 : ti ? 1'b0 : m_shadow;
    nl = (ti | tn) ? 1'b0 : ei ? 1'b1 : di ? 1'b0 : retn ? m_shadow : m_live;
    m_pwe = ld;
    if (ld) m_par = m_shadow;
    m_live = nl; m_shadow = ns;
    if (ei) m_hold = bnd ? SH - 1 : SH;
    else if (bnd && m_hold != 0) m_hold--;
    @(negedge clk);
  endtask

  task automatic drive(input logic e, input logic d, input logic r, input logic l,
                       input logic b, input logic q);
    ei = e; di = d; retn = r; ld = l; bnd = b; req = q;
    step();
  endtask

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk(live | shadow | take_int | take_nmi | par | par_we, 1'b0, "R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(live | shadow | par | par_we, 1'b0, "R1 after release");

    // R3: request while disabled is ignored
    drive(0,0,0,0,1,1);
    // R4: enable at boundary with request pending, then return instruction, then next
    drive(1,0,0,0,1,1);
    drive(0,0,0,0,0,1);
    drive(0,0,0,0,1,1);   // end of instruction after enable: accepted (R5 clears)
    drive(0,0,0,0,1,1);   // flags clear now: not accepted
    // R6 R8: NMI while enabled, then return from NMI (R9), parity after NMI (R10)
    drive(1,0,0,0,1,0);
    nmi_n = 0;
    for (int i = 0; i < 4; i++) drive(0,0,0,0,0,1);
    drive(0,0,0,0,1,1);   // NMI wins over maskable (R7)
    drive(0,0,0,1,0,0);   // load: parity gets shadow = 1
    drive(0,0,0,0,0,0);
    chk(par, 1'b1, "R10 parity after NMI while enabled");
    drive(0,0,1,0,1,0);   // return from NMI restores live
    drive(0,0,0,0,0,0);
    chk(live, 1'b1, "R9 live restored");
    // NMI while disabled
    nmi_n = 1; drive(0,1,0,0,1,0);
    nmi_n = 0;
    for (int i = 0; i < 4; i++) drive(0,0,0,0,0,0);
    drive(0,0,0,0,1,1);
    drive(0,0,0,1,0,0);
    drive(0,0,1,0,1,0);
    drive(0,0,0,0,0,0);
    chk(live | par, 1'b0, "R8 R9 R10 NMI while disabled");
    nmi_n = 1;

    // constrained random
    void'($urandom(32'h1234_5a5a));
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = $urandom_range(0, 9);
      if ($urandom_range(0, 19) == 0) nmi_n = ~nmi_n;
      drive(k == 0 || k == 1, k == 2, k == 3, k == 4,
            $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule